// File: doc/BRIEF.md
# Thread Context Run-State Sequencer

This block keeps the run state of a set of hardware thread contexts in a multithreaded or multiprocessor core. Every context is always in one of four states: vacant (no thread assigned yet), running, parked (a temporary idle state, for example while waiting on a synchronization event) and dead (shut down for good). A context may issue instructions only while it is running. The block exposes that as a per-context execute enable. It also raises one global flag once every context is dead, so the rest of the chip can terminate.

Each context has four request lines: wake, park, free and kill. A wake request carries a delay in cycles. The context becomes running only after that many clock edges have passed, and a delay of zero behaves like a delay of one. While a wake is pending, any new request for the same context cancels it. A new wake restarts the count with its own delay. All contexts leave reset vacant. Contexts with no thread assigned simply receive no wake and stay vacant.

Top module: `thread_status_ctrl`

## Requirements
- R1: After synchronous reset every context reports state code 0 (vacant), every execute enable is 0 and the all-dead flag is 0.
- R2: The state of context i appears on ctx_state[2i+1:2i] with the codes 0 vacant, 1 running, 2 parked, 3 dead. run_en[i] is 1 exactly when that code is 1.
- R3: A wake request with delay D (D at least 1) taken at clock edge E makes the context running after edge E+D, and not before.
- R4: A wake delay of 0 acts exactly like a delay of 1.
- R5: A park request moves a non-dead context to parked at the next edge, which drops its execute enable.
- R6: A free request moves a non-dead context to vacant at the next edge.
- R7: While a wake is pending, a park, free or kill request cancels it. A new wake request restarts the count from its own delay.
- R8: A kill request moves a context to dead at the next edge. A dead context ignores every request until reset.
- R9: When several requests reach one context in the same cycle, kill wins over park, park wins over free, and free wins over wake.
- R10: all_halted is 1 in exactly the cycles where every context reports dead. It rises at the same edge as the last kill takes effect.
- R11: Requests to one context never change the state of another context.
- R12: A wake request to a context that is already running has no effect: the context stays running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wake_req | input | N_CTX | Per-context wake request |
| wake_dly | input | N_CTX*DLY_W | Per-context wake delay, context i in bits [DLY_W*i +: DLY_W] |
| park_req | input | N_CTX | Per-context park request |
| free_req | input | N_CTX | Per-context free request |
| kill_req | input | N_CTX | Per-context kill request |
| ctx_state | output | 2*N_CTX | Per-context state code |
| run_en | output | N_CTX | Per-context execute enable |
| all_halted | output | 1 | Every context is dead |

## Verification
A single context is walked through a table of request patterns. These include wakes with delays of 0, 1, 3 and 2, and a restarted wake. Cancellation by park and by free is covered, with idle cycles held past the old expiry so that an early, late or stale activation shows up. Pairs of simultaneous requests tell each step of the priority order apart. Requests sent to a dead context show whether it is truly sticky. Directed sequences then run contexts side by side to show they stay independent. Contexts are killed one at a time, and later all at once, to show that the all-dead flag rises only on the last kill and clears on reset.

// File: rtl/ctx_pkg.sv
package ctx_pkg;

  typedef enum logic [1:0] {
    ST_VACANT = 2'd0,
    ST_RUN    = 2'd1,
    ST_PARKED = 2'd2,
    ST_DEAD   = 2'd3
  } ctx_st_e;

  typedef enum logic [2:0] {
    OP_NONE = 3'd0,
    OP_WAKE = 3'd1,
    OP_FREE = 3'd2,
    OP_PARK = 3'd3,
    OP_KILL = 3'd4
  } ctx_op_e;

endpackage

// File: rtl/ctx_cmd_arb.sv
module ctx_cmd_arb
  import ctx_pkg::*;
(
  input  logic    wake,
  input  logic    park,
  input  logic    free,
  input  logic    kill,
  output ctx_op_e op
);

  // Fixed priority: kill > park > free > wake
  always_comb begin
    if (kill)      op = OP_KILL;
    else if (park) op = OP_PARK;
    else if (free) op = OP_FREE;
    else if (wake) op = OP_WAKE;
    else           op = OP_NONE;
  end

  always_comb begin
    if (kill) a_r9_kill_first: assert (op == OP_KILL);
    if (!kill && park) a_r9_park_over_free: assert (op == OP_PARK);
  end

endmodule

// File: rtl/ctx_slot.sv
module ctx_slot
  import ctx_pkg::*;
#(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  ctx_op_e          op,
  input  logic [DLY_W-1:0] dly,
  output ctx_st_e          state_q,
  output ctx_st_e          state_d,
  output logic             run_q
);

  localparam logic [DLY_W-1:0] ONE = {{(DLY_W-1){1'b0}}, 1'b1};

  logic             pend_q, pend_d;
  logic [DLY_W-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    pend_d  = pend_q;
    cnt_d   = cnt_q;
    if (state_q != ST_DEAD) begin
      unique case (op)
        OP_KILL: begin state_d = ST_DEAD;   pend_d = 1'b0; end
        OP_PARK: begin state_d = ST_PARKED; pend_d = 1'b0; end
        OP_FREE: begin state_d = ST_VACANT; pend_d = 1'b0; end
        OP_WAKE: begin
          if (state_q != ST_RUN) begin
            pend_d = 1'b1;
            cnt_d  = (dly == '0) ? ONE : dly;
          end
        end
        default: begin
          if (pend_q) begin
            if (cnt_q <= ONE) begin
              state_d = ST_RUN;
              pend_d  = 1'b0;
            end else begin
              cnt_d = cnt_q - ONE;
            end
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_VACANT;
      pend_q  <= 1'b0;
      cnt_q   <= '0;
      run_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
      cnt_q   <= cnt_d;
      run_q   <= (state_d == ST_RUN);
    end
  end

  a_r8_dead_sticky: assert property (@(posedge clk) disable iff (rst)
    state_q == ST_DEAD |=> state_q == ST_DEAD);

  a_r8_kill_lands: assert property (@(posedge clk) disable iff (rst)
    op == OP_KILL |=> state_q == ST_DEAD);

  a_r5_park_lands: assert property (@(posedge clk) disable iff (rst)
    (op == OP_PARK && state_q != ST_DEAD) |=> state_q == ST_PARKED);

  a_r6_free_lands: assert property (@(posedge clk) disable iff (rst)
    (op == OP_FREE && state_q != ST_DEAD) |=> state_q == ST_VACANT);

  a_r7_cancel: assert property (@(posedge clk) disable iff (rst)
    (pend_q && (op == OP_PARK || op == OP_FREE || op == OP_KILL)) |=> !pend_q);

  a_r3_wake_on_expiry: assert property (@(posedge clk) disable iff (rst)
    $rose(state_q == ST_RUN) |-> $past(pend_q && op == OP_NONE));

  a_r2_run_matches: assert property (@(posedge clk) disable iff (rst)
    run_q == (state_q == ST_RUN));

endmodule

// File: rtl/ctx_done_detect.sv
module ctx_done_detect #(
  parameter int N_CTX = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_CTX-1:0] dead_next,
  output logic             all_dead_q
);

  always_ff @(posedge clk) begin
    if (rst) all_dead_q <= 1'b0;
    else     all_dead_q <= &dead_next;
  end

endmodule

// File: rtl/thread_status_ctrl.sv
module thread_status_ctrl
  import ctx_pkg::*;
#(
  parameter int N_CTX = 4,
  parameter int DLY_W = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [N_CTX-1:0]       wake_req,
  input  logic [N_CTX*DLY_W-1:0] wake_dly,
  input  logic [N_CTX-1:0]       park_req,
  input  logic [N_CTX-1:0]       free_req,
  input  logic [N_CTX-1:0]       kill_req,
  output logic [2*N_CTX-1:0]     ctx_state,
  output logic [N_CTX-1:0]       run_en,
  output logic                   all_halted
);

  logic [N_CTX-1:0] dead_next;
  logic [N_CTX-1:0] dead_now;

  for (genvar i = 0; i < N_CTX; i++) begin : g_ctx
    ctx_op_e op;
    ctx_st_e st_q, st_d;

    ctx_cmd_arb u_arb (
      .wake (wake_req[i]),
      .park (park_req[i]),
      .free (free_req[i]),
      .kill (kill_req[i]),
      .op   (op)
    );

    ctx_slot #(.DLY_W(DLY_W)) u_slot (
      .clk     (clk),
      .rst     (rst),
      .op      (op),
      .dly     (wake_dly[DLY_W*i +: DLY_W]),
      .state_q (st_q),
      .state_d (st_d),
      .run_q   (run_en[i])
    );

    assign ctx_state[2*i +: 2] = st_q;
    assign dead_next[i]        = (st_d == ST_DEAD);
    assign dead_now[i]         = (ctx_state[2*i +: 2] == 2'd3);
  end

  ctx_done_detect #(.N_CTX(N_CTX)) u_done (
    .clk        (clk),
    .rst        (rst),
    .dead_next  (dead_next),
    .all_dead_q (all_halted)
  );

  a_r10_flag_matches: assert property (@(posedge clk) disable iff (rst)
    all_halted == (&dead_now));

  a_r1_reset_clean: assert property (@(posedge clk)
    rst |=> (ctx_state == '0 && run_en == '0 && !all_halted));

endmodule

// File: tb/sim_thread_status_ctrl.sv
module sim_thread_status_ctrl;

  localparam int N  = 4;
  localparam int DW = 8;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [N-1:0]    wake_req = '0, park_req = '0, free_req = '0, kill_req = '0;
  logic [N*DW-1:0] wake_dly = '0;
  logic [2*N-1:0]  ctx_state;
  logic [N-1:0]    run_en;
  logic            all_halted;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  thread_status_ctrl #(.N_CTX(N), .DLY_W(DW)) u0 (
    .clk(clk), .rst(rst), .wake_req(wake_req), .wake_dly(wake_dly),
    .park_req(park_req), .free_req(free_req), .kill_req(kill_req),
    .ctx_state(ctx_state), .run_en(run_en), .all_halted(all_halted)
  );

  // Entry: {kill, park, free, wake, dly[7:0], expected state[1:0]} for context 0
  localparam int NV = 32;
  localparam logic [13:0] VEC [NV] = '{
    {4'b0001, 8'd1, 2'd0}, {4'b0000, 8'd0, 2'd1}, // R3 delay 1
    {4'b0001, 8'd5, 2'd1},                         // R12 wake while running
    {4'b0100, 8'd0, 2'd2},                         // R5 park
    {4'b0001, 8'd3, 2'd2}, {4'b0000, 8'd0, 2'd2},
    {4'b0000, 8'd0, 2'd2}, {4'b0000, 8'd0, 2'd1}, // R3 delay 3
    {4'b0010, 8'd0, 2'd0},                         // R6 free
    {4'b0001, 8'd0, 2'd0}, {4'b0000, 8'd0, 2'd1}, // R4 delay 0
    {4'b0100, 8'd0, 2'd2},
    {4'b0001, 8'd4, 2'd2}, {4'b0000, 8'd0, 2'd2},
    {4'b0001, 8'd2, 2'd2}, {4'b0000, 8'd0, 2'd2},
    {4'b0000, 8'd0, 2'd1},                         // R7 restart
    {4'b0101, 8'd1, 2'd2},                         // R9 park over wake
    {4'b0001, 8'd4, 2'd2}, {4'b0010, 8'd0, 2'd0}, // R7 cancel by free
    {4'b0000, 8'd0, 2'd0}, {4'b0000, 8'd0, 2'd0},
    {4'b0000, 8'd0, 2'd0}, {4'b0000, 8'd0, 2'd0},
    {4'b0011, 8'd1, 2'd0}, {4'b0000, 8'd0, 2'd0}, // R9 free over wake
    {4'b0110, 8'd0, 2'd2},                         // R9 park over free
    {4'b1100, 8'd0, 2'd3},                         // R9 kill over park
    {4'b0001, 8'd1, 2'd3}, {4'b0000, 8'd0, 2'd3}, // R8 dead ignores
    {4'b0010, 8'd0, 2'd3}, {4'b0100, 8'd0, 2'd3}
  };

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int st(input int c);
    return int'(ctx_state[2*c +: 2]);
  endfunction

  task automatic clear_in();
    wake_req = '0; park_req = '0; free_req = '0; kill_req = '0; wake_dly = '0;
  endtask

  task automatic tick();
    @(negedge clk);
    clear_in();
  endtask

  task automatic do_reset();
    rst = 1'b1;
    tick();
    tick();
    rst = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk + 1 - n_bad, n_chk + 1);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R1 reset state
    for (int c = 0; c < N; c++) check($sformatf("R1 state ctx%0d", c), st(c), 0);
    check("R1 run_en", int'(run_en), 0);
    check("R1 all_halted", int'(all_halted), 0);

    // Table on context 0
    for (int v = 0; v < NV; v++) begin
      {kill_req[0], park_req[0], free_req[0], wake_req[0]} = VEC[v][13:10];
      wake_dly[DW-1:0] = VEC[v][9:2];
      tick();
      check($sformatf("R2/R3-R9 vec%0d state", v), st(0), int'(VEC[v][1:0]));
      check($sformatf("R2 vec%0d run_en", v), int'(run_en[0]), int'(VEC[v][1:0] == 2'd1));
      check($sformatf("R11 vec%0d others", v), int'(ctx_state[2*N-1:2]), 0);
      check($sformatf("R10 vec%0d flag", v), int'(all_halted), 0);
    end

    // R11 independence: ctx1 parked, ctx2 wakes with delay 2
    park_req[1] = 1'b1;
    wake_req[2] = 1'b1; wake_dly[2*DW +: DW] = 8'd2;
    tick();
    check("R11 ctx1 parked", st(1), 2);
    check("R11 ctx2 pending", st(2), 0);
    tick();
    check("R11 ctx2 still pending", st(2), 0);
    check("R11 ctx1 unchanged", st(1), 2);
    tick();
    check("R11 ctx2 running", st(2), 1);
    check("R11 ctx3 untouched", st(3), 0);
    check("R2 run_en pattern", int'(run_en), 4'b0100);

    // R10 kill one at a time (ctx0 already dead)
    kill_req[1] = 1'b1; kill_req[2] = 1'b1;
    tick();
    check("R10 three dead flag low", int'(all_halted), 0);
    check("R8 ctx2 dead", st(2), 3);
    kill_req[3] = 1'b1;
    tick();
    check("R10 last kill raises flag", int'(all_halted), 1);
    wake_req = '1; free_req = '1;
    tick();
    check("R8 all stay dead", int'(ctx_state), 8'hFF);
    check("R10 flag holds", int'(all_halted), 1);

    // R1 reset clears dead state
    do_reset();
    check("R1 reset clears dead", int'(ctx_state), 0);
    check("R1 reset clears flag", int'(all_halted), 0);

    // R10 all killed at once, mixed with wake
    wake_req = '1;
    kill_req = '1;
    tick();
    check("R10 simultaneous kill", int'(all_halted), 1);
    check("R9 kill over wake", int'(ctx_state), 8'hFF);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule